// File: doc/BRIEF.md
# Host Bus Slave Port with Refresh Arbitration

This block is the CPU-facing access port of a display controller. A host reads and writes 16-bit words of an internal store over a 16-bit address bus and a 16-bit bidirectional data bus. Every transfer is timed by a bus clock that is separate from the pixel clock. The display side also reads the same store to refresh the panel. Only one requester can use the store in a given cycle, so the port arbitrates, and it holds the host with an active-low wait output until read data is on the bus or write data has been stored.

An access needs chip select low together with either the read strobe or the write strobe. The write strobe always covers the lower data lane. A separate high-byte enable gates the upper lane on both reads and writes. Two configuration pins are captured during reset and ignored afterwards. One selects the byte order between the bus and the store. The other sets the polarity of a panel power output. Refresh requests are assumed to be already synchronous to the bus clock. A refresh read is granted combinationally, and its word appears one cycle later.

Top module: `hostBusPort`

## Requirements
- R1: While reset is applied and immediately after it is released, `waitN` is 1, `refValid` is 0 and `refAck` is 0.
- R2: While `csN` is 1, the write and read strobes have no effect: no word is stored and `waitN` stays 1.
- R3: The port drives the data bus only while `csN` and `rdN` are both 0. A read with the high-byte enable active returns the full stored word, adjusted for byte order.
- R4: During a read with `hiEnN` = 1, the upper lane `data[15:8]` is not driven, and the lower lane still returns its byte.
- R5: A write (`csN` = 0, `weLoN` = 0) always stores bus lane `data[7:0]`. It stores bus lane `data[15:8]` only when `hiEnN` = 0. A disabled lane leaves its stored byte unchanged.
- R6: With little-endian order (`cfgBigEnd` = 0 at reset), bus bits [15:8] map to stored bits [15:8]. With big-endian order (`cfgBigEnd` = 1), bus bits [15:8] map to stored bits [7:0] and bus bits [7:0] map to stored bits [15:8], in both directions. The refresh port returns the stored word unchanged.
- R7: Take a host request that meets no refresh request. `waitN` goes to 0 in the cycle the request appears and to 1 one clock later. Read data is valid on the bus one clock after that, and the write is committed at that same edge.
- R8: When a refresh request and a host request are both present in the same idle cycle, the refresh wins. `refAck` is 1 in that cycle, `refValid` and `refData` follow one clock later, and the host's `waitN` stays 0 for one extra cycle.
- R9: A refresh request that arrives while a host access owns the store is not acknowledged (`refAck` = 0). It is acknowledged in the next cycle.
- R10: `cfgBigEnd` and `cfgPwrHigh` are sampled only while `rstN` is 0. Pin changes after reset has been released have no effect.
- R11: `panelPwr` equals `pwrOn` when `cfgPwrHigh` was 1 at reset, and equals the inverse of `pwrOn` when it was 0.
- R12: A host access is performed once. While the strobes stay asserted after completion, `waitN` stays 1, and changed bus data is not stored again until the strobes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Host bus clock; all logic is synchronous to it |
| rstN | input | 1 | Active-low synchronous reset; configuration pins are captured while low |
| cfgBigEnd | input | 1 | Byte-order selection, 1 = swap the two bytes between bus and store |
| cfgPwrHigh | input | 1 | Panel power polarity, 1 = active high |
| addr | input | 16 | Host word address; the low bits select the store word |
| data | inout | 16 | Host data bus |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| weLoN | input | 1 | Active-low write strobe, lower lane |
| hiEnN | input | 1 | Active-low upper-lane enable for reads and writes |
| waitN | output | 1 | Active-low host stall |
| refReq | input | 1 | Display refresh read request |
| refAddr | input | 8 | Refresh word index |
| refAck | output | 1 | Refresh request granted this cycle |
| refData | output | 16 | Refresh word, stored order |
| refValid | output | 1 | refData is valid (one cycle after refAck) |
| pwrOn | input | 1 | Logical panel power request |
| panelPwr | output | 1 | Panel power pin with the latched polarity applied |

## Verification
A wrong arbitration state shows up first on `waitN` and `refAck`. A port stuck in its grant state drops refresh acknowledgements. A port that misses a grant leaves the host stalled one clock past the cycle the bench expects. A wrong byte-order or lane-enable state does not change any timing. It shows up only as misplaced bytes, on the data bus two clocks after a read begins or on `refData` one clock after the following refresh fetch. A repeated commit while the strobes are held shows up only at the next refresh read of that word.

// File: rtl/hbpPkg.sv
package hbpPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_DONE  = 2'd2
  } hbpState_e;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic hostWr;    // commit host write this cycle
    logic hostRd;    // capture host read word this cycle
    logic laneHiEn;  // upper bus lane enabled
    logic bigEnd;    // latched byte order
    logic refRd;     // refresh read granted this cycle
  } hbpStrb_t;

endpackage

// File: rtl/hbpCtrl.sv
module hbpCtrl
  import hbpPkg::*;
(
  input  logic     busClk,
  input  logic     rstN,
  input  logic     cfgBigEnd,
  input  logic     cfgPwrHigh,
  input  logic     csN,
  input  logic     rdN,
  input  logic     weLoN,
  input  logic     hiEnN,
  input  logic     refReq,
  input  logic     pwrOn,
  output logic     waitN,
  output logic     refAck,
  output logic     panelPwr,
  output hbpStrb_t strb
);

  hbpState_e state, stateNext;
  logic hostReq;
  logic bigEndReg;
  logic pwrHighReg;

  assign hostReq = !csN && (!rdN || !weLoN);

  // configuration capture: follows pins only while reset is held
  always_ff @(posedge busClk) begin
    if (!rstN) begin
      bigEndReg  <= cfgBigEnd;
      pwrHighReg <= cfgPwrHigh;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (hostReq && !refReq) stateNext = ST_GRANT;
      ST_GRANT: stateNext = ST_DONE;
      ST_DONE:  if (!hostReq) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge busClk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign waitN    = !(hostReq && (state == ST_IDLE));
  assign refAck   = refReq && (state != ST_GRANT);
  assign panelPwr = pwrHighReg ? pwrOn : !pwrOn;

  always_comb begin
    strb.hostWr   = (state == ST_GRANT) && !csN && !weLoN;
    strb.hostRd   = (state == ST_GRANT) && !csN && weLoN && !rdN;
    strb.laneHiEn = !hiEnN;
    strb.bigEnd   = bigEndReg;
    strb.refRd    = refAck;
  end

  AST_WAIT_CLEARS: assert property (@(posedge busClk) disable iff (!rstN)
    (hostReq && !waitN && !refReq) |=> waitN); // R7
  AST_REF_STALLS: assert property (@(posedge busClk) disable iff (!rstN)
    (hostReq && !waitN && refReq) |=> (!waitN || !hostReq)); // R8
  AST_ONE_OWNER: assert property (@(posedge busClk) disable iff (!rstN)
    !(refAck && (strb.hostWr || strb.hostRd))); // R9
  AST_SINGLE_COMMIT: assert property (@(posedge busClk) disable iff (!rstN)
    strb.hostWr |=> !strb.hostWr); // R12
  AST_CFG_STABLE: assert property (@(posedge busClk) disable iff (!rstN)
    $past(rstN) |-> ($stable(bigEndReg) && $stable(pwrHighReg))); // R10

endmodule

// File: rtl/hbpDatapath.sv
module hbpDatapath
  import hbpPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int MEM_WORDS = 256,
  localparam int IDX_W    = $clog2(MEM_WORDS),
  localparam int LANES    = DATA_W / 8
) (
  input  logic              busClk,
  input  logic              rstN,
  input  hbpStrb_t          strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] busIn,
  input  logic              csN,
  input  logic              rdN,
  input  logic [IDX_W-1:0]  refAddr,
  output logic [DATA_W-1:0] busOut,
  output logic [LANES-1:0]  laneDrv,
  output logic [DATA_W-1:0] refData,
  output logic              refValid
);

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] inWord;
  logic [LANES-1:0]  storeEn;
  logic [IDX_W-1:0]  hostIdx;
  logic              unusedAddrHi;

  assign hostIdx      = addr[IDX_W-1:0];
  assign unusedAddrHi = ^addr[ADDR_W-1:IDX_W];

  function automatic logic [DATA_W-1:0] laneSwap(input logic [DATA_W-1:0] w, input logic en);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*8 +: 8] = en ? w[(LANES-1-i)*8 +: 8] : w[i*8 +: 8];
    return r;
  endfunction

  assign inWord = laneSwap(busIn, strb.bigEnd);
  assign busOut = laneSwap(rdWord, strb.bigEnd);

  // stored lane s comes from bus lane b; only the top bus lane is gated
  always_comb begin
    for (int s = 0; s < LANES; s++) begin
      automatic int b = strb.bigEnd ? (LANES - 1 - s) : s;
      storeEn[s] = (b != LANES - 1) || strb.laneHiEn;
    end
  end

  always_ff @(posedge busClk) begin
    if (strb.hostWr) begin
      for (int s = 0; s < LANES; s++)
        if (storeEn[s]) mem[hostIdx][s*8 +: 8] <= inWord[s*8 +: 8];
    end
    if (strb.hostRd) rdWord <= mem[hostIdx];
    if (strb.refRd)  refData <= mem[refAddr];
  end

  always_ff @(posedge busClk) begin
    if (!rstN) refValid <= 1'b0;
    else       refValid <= strb.refRd;
  end

  // output enables per bus lane
  generate
    for (genvar g = 0; g < LANES; g++) begin : gLaneDrv
      if (g == LANES - 1) begin : gTop
        assign laneDrv[g] = !csN && !rdN && strb.laneHiEn;
      end else begin : gLow
        assign laneDrv[g] = !csN && !rdN;
      end
    end
  endgenerate

  AST_WR_NEEDS_SELECT: assert property (@(posedge busClk) disable iff (!rstN)
    strb.hostWr |-> !csN); // R2

endmodule

// File: rtl/hostBusPort.sv
module hostBusPort
  import hbpPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int MEM_WORDS = 256
) (
  input  logic                         busClk,
  input  logic                         rstN,
  input  logic                         cfgBigEnd,
  input  logic                         cfgPwrHigh,
  input  logic [ADDR_W-1:0]            addr,
  inout  wire  [DATA_W-1:0]            data,
  input  logic                         csN,
  input  logic                         rdN,
  input  logic                         weLoN,
  input  logic                         hiEnN,
  output logic                         waitN,
  input  logic                         refReq,
  input  logic [$clog2(MEM_WORDS)-1:0] refAddr,
  output logic                         refAck,
  output logic [DATA_W-1:0]            refData,
  output logic                         refValid,
  input  logic                         pwrOn,
  output logic                         panelPwr
);

  localparam int LANES = DATA_W / 8;

  hbpStrb_t          strb;
  logic [DATA_W-1:0] busOut;
  logic [LANES-1:0]  laneDrv;

  hbpCtrl uCtrl (
    .busClk(busClk), .rstN(rstN), .cfgBigEnd(cfgBigEnd), .cfgPwrHigh(cfgPwrHigh),
    .csN(csN), .rdN(rdN), .weLoN(weLoN), .hiEnN(hiEnN), .refReq(refReq),
    .pwrOn(pwrOn), .waitN(waitN), .refAck(refAck), .panelPwr(panelPwr), .strb(strb)
  );

  hbpDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) uData (
    .busClk(busClk), .rstN(rstN), .strb(strb), .addr(addr), .busIn(data),
    .csN(csN), .rdN(rdN), .refAddr(refAddr), .busOut(busOut), .laneDrv(laneDrv),
    .refData(refData), .refValid(refValid)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : gBus
      assign data[g*8 +: 8] = laneDrv[g] ? busOut[g*8 +: 8] : 8'hzz;
    end
  endgenerate

  AST_REF_LATENCY: assert property (@(posedge busClk) disable iff (!rstN)
    refAck |=> refValid); // R8

endmodule

// File: tb/sim_hostBusPort.sv
module sim_hostBusPort;

  logic        busClk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgBigEnd = 1'b0, cfgPwrHigh = 1'b0;
  logic [15:0] addr = '0;
  wire  [15:0] data;
  logic        csN = 1'b1, rdN = 1'b1, weLoN = 1'b1, hiEnN = 1'b1;
  logic        waitN, refAck, refValid, panelPwr;
  logic        refReq = 1'b0;
  logic [7:0]  refAddr = '0;
  logic [15:0] refData;
  logic        pwrOn = 1'b0;
  logic [15:0] dataDrv = '0;
  logic        benchLo = 1'b0, benchHi = 1'b0;
  int          checks = 0, errors = 0;

  always #10 busClk = ~busClk;

  assign data[7:0]  = benchLo ? dataDrv[7:0]  : 8'hzz;
  assign data[15:8] = benchHi ? dataDrv[15:8] : 8'hzz;

  hostBusPort u0 (
    .busClk(busClk), .rstN(rstN), .cfgBigEnd(cfgBigEnd), .cfgPwrHigh(cfgPwrHigh),
    .addr(addr), .data(data), .csN(csN), .rdN(rdN), .weLoN(weLoN), .hiEnN(hiEnN),
    .waitN(waitN), .refReq(refReq), .refAddr(refAddr), .refAck(refAck),
    .refData(refData), .refValid(refValid), .pwrOn(pwrOn), .panelPwr(panelPwr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic release_bus();
    csN = 1; rdN = 1; weLoN = 1; hiEnN = 1; benchLo = 0; benchHi = 0;
  endtask

  task automatic doReset(input logic big, input logic pwrHigh);
    @(negedge busClk);
    rstN = 0; cfgBigEnd = big; cfgPwrHigh = pwrHigh;
    repeat (3) @(negedge busClk);
    #1 check("R1 wait in reset", waitN, 1);
    check("R1 refValid in reset", refValid, 0);
    @(negedge busClk); rstN = 1;
    #1 check("R1 wait after reset", waitN, 1);
    check("R1 refAck after reset", refAck, 0);
    cfgBigEnd = !big; cfgPwrHigh = !pwrHigh;   // R10: late pin changes
  endtask

  task automatic hostWrite(input logic [15:0] a, input logic [15:0] v, input logic hiOn);
    @(negedge busClk);
    addr = a; dataDrv = v; benchLo = 1; benchHi = 1; csN = 0; weLoN = 0; hiEnN = !hiOn;
    #1 check("R7 write wait low", waitN, 0);
    @(negedge busClk); #1 check("R7 write wait high", waitN, 1);
    @(negedge busClk); #1 release_bus();
  endtask

  task automatic hostRead(input logic [15:0] a, input logic hiOn, input logic [15:0] exp, input string req);
    @(negedge busClk);
    addr = a; csN = 0; rdN = 0; hiEnN = !hiOn; dataDrv = 16'h0000; benchHi = !hiOn;
    #1 check("R7 read wait low", waitN, 0);
    @(negedge busClk); #1 check("R7 read wait high", waitN, 1);
    @(negedge busClk); #1 check(req, data, hiOn ? exp : {8'h00, exp[7:0]});
    release_bus();
  endtask

  task automatic refFetch(input logic [7:0] idx, input logic [15:0] exp, input string req);
    @(negedge busClk);
    refAddr = idx; refReq = 1;
    #1 check("R8 refAck idle", refAck, 1);
    @(negedge busClk); refReq = 0;
    #1 check("R8 refValid", refValid, 1);
    check(req, refData, exp);
  endtask

  task automatic testPower(input logic on, input logic exp);
    pwrOn = on; #1 check("R11 R10 panelPwr", panelPwr, exp);
  endtask

  task automatic testNoSelect();
    @(negedge busClk);
    addr = 16'h0010; dataDrv = 16'hDEAD; benchLo = 1; benchHi = 1; csN = 1; weLoN = 0; hiEnN = 0;
    #1 check("R2 wait without select", waitN, 1);
    repeat (2) @(negedge busClk);
    #1 release_bus();
    refFetch(8'h10, 16'h1256, "R2 no store without select");
  endtask

  task automatic testFloat();
    @(negedge busClk);
    addr = 16'h0010; dataDrv = 16'h0000; benchLo = 1; benchHi = 1;
    csN = 0; rdN = 1; hiEnN = 0;
    #1 check("R3 float rd high", data, 16'h0000);
    csN = 1; rdN = 0;
    #1 check("R3 float cs high", data, 16'h0000);
    release_bus();
  endtask

  task automatic testCollision();
    @(negedge busClk);
    addr = 16'h0010; csN = 0; rdN = 0; hiEnN = 0; refAddr = 8'h10; refReq = 1;
    #1 check("R8 refresh wins ack", refAck, 1);
    check("R8 host waits", waitN, 0);
    @(negedge busClk); refReq = 0;
    #1 check("R8 refValid", refValid, 1);
    check("R8 refData", refData, 16'h1256);
    check("R8 extra wait", waitN, 0);
    @(negedge busClk); #1 check("R8 wait released", waitN, 1);
    @(negedge busClk); #1 check("R8 host data", data, 16'h1256);
    release_bus();
  endtask

  task automatic testRefInGrant();
    @(negedge busClk);
    addr = 16'h0010; csN = 0; rdN = 0; hiEnN = 0;
    @(negedge busClk); refAddr = 8'h10; refReq = 1;
    #1 check("R9 no ack during grant", refAck, 0);
    @(negedge busClk); #1 check("R9 ack next cycle", refAck, 1);
    check("R9 host data", data, 16'h1256);
    @(negedge busClk); refReq = 0;
    #1 check("R9 refValid", refValid, 1);
    check("R9 refData", refData, 16'h1256);
    release_bus();
  endtask

  task automatic testHold();
    @(negedge busClk);
    addr = 16'h0030; dataDrv = 16'h4321; benchLo = 1; benchHi = 1; csN = 0; weLoN = 0; hiEnN = 0;
    repeat (2) @(negedge busClk);
    dataDrv = 16'h9999;
    repeat (2) @(negedge busClk);
    #1 check("R12 wait high while held", waitN, 1);
    release_bus();
    refFetch(8'h30, 16'h4321, "R12 single commit");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset(1'b0, 1'b1);
    testPower(1'b1, 1'b1);
    testPower(1'b0, 1'b0);
    hostWrite(16'h0010, 16'h1234, 1'b1);
    refFetch(8'h10, 16'h1234, "R6 R5 little full write");
    hostWrite(16'h0010, 16'hFF56, 1'b0);
    refFetch(8'h10, 16'h1256, "R5 upper lane masked");
    hostRead(16'h0010, 1'b1, 16'h1256, "R3 full read");
    hostRead(16'h0010, 1'b0, 16'h1256, "R4 upper lane undriven");
    testFloat();
    testNoSelect();
    testCollision();
    testRefInGrant();
    testHold();

    doReset(1'b1, 1'b0);
    testPower(1'b1, 1'b0);
    hostWrite(16'h0020, 16'hA1B2, 1'b1);
    refFetch(8'h20, 16'hB2A1, "R6 R10 big write swapped");
    hostRead(16'h0020, 1'b1, 16'hA1B2, "R6 big read swapped");
    hostWrite(16'h0020, 16'h77C3, 1'b0);
    refFetch(8'h20, 16'hC3A1, "R6 R5 big partial write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule